// File: doc/BRIEF.md
# Serial EEPROM Write Slave with One-Time Page

This block is the write side of a two-wire serial EEPROM, built as a slave clocked by the system clock. It filters the bus lines through synchronizers and recognises start and stop conditions. It decodes a device select byte, takes a two-byte address, and buffers one data byte or a run of data bytes in a page buffer. The target is either the main byte array or a 16-byte one-time page. A write-control input, whose active level is chosen by a second input, decides whether data bytes are taken.

A stop that closes a transfer with buffered data opens an internal write window of `TWR_CYCLES` clocks. In the first clocks of that window the buffered bytes leave through a byte-wide write port, one per clock, toward the storage array. For the whole window the block stays off the bus, so a master learns that the write is finished by sending a select byte until it is acknowledged.

Top module: `eeprom_wr_slave`

## Requirements
- R1: A select byte of 0xA0 (family 1010, bank bits 000, write bit 0) is acknowledged and targets the main array. A select byte of 0xA2 (bank bits 001) is acknowledged and targets the one-time page. Any other select byte, including one with bit 0 set, is not acknowledged, and the rest of that transfer gets no acknowledge until the next start.
- R2: After an accepted select byte, the high address byte and then the low address byte are each acknowledged. Main-array writes use the low `log2(MEM_BYTES)` bits of the 16-bit address.
- R3: A byte write (select, two address bytes, one data byte, stop) acknowledges the data byte. The stop then produces exactly one `memWe` pulse carrying that byte and its address, inside an internal write window of `TWR_CYCLES` clocks.
- R4: A page write acknowledges every data byte, however many are sent. Data bytes fill the 16-byte page buffer from the low four address bits, wrapping inside the page, and a later byte replaces an earlier one in the same slot. The stop writes each filled slot once, at page base plus slot.
- R5: For a one-time page write, a low address byte of 0x00 is valid, and its data goes out with `memOtp`=1 at addresses 0 to 15. Any other low address byte is still acknowledged, but every data byte after it is not acknowledged, and no write takes place.
- R6: During the internal write window `sdaPullDown` stays deasserted, so a select byte is not acknowledged.
- R7: After the window ends, a select byte is acknowledged. The address and data bytes that follow in the same transfer are taken without a second select byte.
- R8: Data bytes are taken only while `wcPin` equals `wcPol`. Otherwise they are not acknowledged and no write takes place.
- R9: A stop after a transfer that took no data byte starts no internal write window.
- R10: A repeated start before the stop discards the bytes buffered so far. A stop after it starts no write.
- R11: After reset `sdaPullDown` and `memWe` are low, and a select byte is acknowledged at once.
- R12: `sdaPullDown` is asserted only in the acknowledge slot after a byte. It is deasserted again while the master sends data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| wcPin | input | 1 | Write-control level |
| wcPol | input | 1 | Level of `wcPin` that allows writes |
| sdaPullDown | output | 1 | Drives the data line low when 1 (open drain) |
| memWe | output | 1 | Storage write strobe |
| memOtp | output | 1 | Write targets the one-time page |
| memAddr | output | log2(MEM_BYTES) | Storage write address |
| memData | output | 8 | Storage write data |

## Verification
A wrong bit count or state in the byte engine shows up as an acknowledge in the wrong slot or a missing one. The master sees this at the ninth clock of the affected byte, well before any stop. Buffer-slot or pointer errors show up only at the stop, as `memWe` pulses with wrong addresses or data in the first clocks of the write window. A wrong window length shows up as an acknowledge or refusal on the first select byte sent after a stop. For this reason every scenario ends with a probe select byte and a comparison of the recorded writes against a model array.

// File: rtl/eew_pkg.sv
package eew_pkg;

  localparam logic [3:0] SEL_FAMILY = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_DATA,
    ST_IGNORE
  } busState_t;

  // control -> datapath strobes (selOtp is a level)
  typedef struct packed {
    logic clearBuf;
    logic loadHi;
    logic loadLo;
    logic pushData;
    logic commit;
    logic selOtp;
  } ctlStrobe_t;

endpackage

// File: rtl/eew_ctrl.sv
module eew_ctrl
  import eew_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [2:0]  MAIN_SEL    = 3'b000,
  parameter logic [2:0]  OTP_SEL     = 3'b001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wcPin,
  input  logic       wcPol,
  input  logic       busy,
  output ctlStrobe_t strb,
  output logic [7:0] rxByte,
  output logic       sdaPullDown
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  logic sclRise, sclFall, startSeen, stopSeen;
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic       ackSlot, selOtpQ, addrBad;

  logic byteDone, ackEnd, selOk, wrOk, giveAck;
  assign byteDone = sclFall && !ackSlot && (bitCnt == 4'd8) && (state != ST_IDLE);
  assign ackEnd   = sclFall && ackSlot;
  assign selOk    = (shiftReg[7:4] == SEL_FAMILY) && !shiftReg[0] &&
                    ((shiftReg[3:1] == MAIN_SEL) || (shiftReg[3:1] == OTP_SEL));
  assign wrOk     = (wcPin == wcPol) && !addrBad;

  always_comb begin
    unique case (state)
      ST_DEVSEL:  giveAck = selOk;
      ST_ADDR_HI: giveAck = 1'b1;
      ST_ADDR_LO: giveAck = 1'b1;
      ST_DATA:    giveAck = wrOk;
      default:    giveAck = 1'b0;
    endcase
  end

  always_comb begin
    strb.clearBuf = startSeen && !busy;
    strb.loadHi   = byteDone && (state == ST_ADDR_HI);
    strb.loadLo   = byteDone && (state == ST_ADDR_LO);
    strb.pushData = byteDone && (state == ST_DATA) && wrOk;
    strb.commit   = stopSeen && !busy && (state == ST_DATA);
    strb.selOtp   = selOtpQ;
  end

  assign rxByte = shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      shiftReg    <= '0;
      ackSlot     <= 1'b0;
      sdaPullDown <= 1'b0;
      selOtpQ     <= 1'b0;
      addrBad     <= 1'b0;
    end else if (busy) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      ackSlot     <= 1'b0;
      sdaPullDown <= 1'b0;
    end else if (startSeen) begin
      state       <= ST_DEVSEL;
      bitCnt      <= '0;
      ackSlot     <= 1'b0;
      sdaPullDown <= 1'b0;
    end else if (stopSeen) begin
      state       <= ST_IDLE;
      ackSlot     <= 1'b0;
      sdaPullDown <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise && !ackSlot && (bitCnt < 4'd8)) begin
        shiftReg <= {shiftReg[6:0], sdaNow};
        bitCnt   <= bitCnt + 4'd1;
      end
      if (byteDone) begin
        ackSlot     <= 1'b1;
        sdaPullDown <= giveAck;
        if (state == ST_DEVSEL) selOtpQ <= (shiftReg[3:1] == OTP_SEL);
        if (state == ST_ADDR_LO) addrBad <= selOtpQ && (shiftReg != 8'h00);
      end
      if (ackEnd) begin
        ackSlot     <= 1'b0;
        sdaPullDown <= 1'b0;
        bitCnt      <= '0;
        unique case (state)
          ST_DEVSEL:  state <= selOk ? ST_ADDR_HI : ST_IGNORE;
          ST_ADDR_HI: state <= ST_ADDR_LO;
          ST_ADDR_LO: state <= ST_DATA;
          default:    state <= state;
        endcase
      end
    end
  end

endmodule

// File: rtl/eew_data.sv
module eew_data
  import eew_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16,
  parameter int TWR_CYCLES = 600,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int TW = $clog2(TWR_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctlStrobe_t    strb,
  input  logic [7:0]    rxByte,
  output logic          busy,
  output logic          memWe,
  output logic          memOtp,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memData
);

  logic [7:0]            addrHiByte, addrLoByte;
  logic [15:0]           addrFull;
  logic                  tgtOtp;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [PW-1:0]         fillPtr, flushIdx, slotIdx;
  logic                  flushing;
  logic [TW-1:0]         busyCnt;
  logic [AW-1:0]         flushAddr;

  assign addrFull = {addrHiByte, addrLoByte};
  assign slotIdx  = addrFull[PW-1:0] + fillPtr;
  assign busy     = (busyCnt != '0);

  generate
    if (AW < 16) begin : g_addr_spare
      logic unusedAddrBits;
      assign unusedAddrBits = ^addrFull[15:AW];
    end
  endgenerate

  assign flushAddr = tgtOtp ? {{(AW-PW){1'b0}}, flushIdx}
                            : {addrFull[AW-1:PW], flushIdx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrHiByte <= '0;
      addrLoByte <= '0;
      tgtOtp     <= 1'b0;
      validMask  <= '0;
      fillPtr    <= '0;
      flushIdx   <= '0;
      flushing   <= 1'b0;
      busyCnt    <= '0;
    end else begin
      if (strb.clearBuf) begin
        validMask <= '0;
        fillPtr   <= '0;
      end
      if (strb.loadHi) begin
        addrHiByte <= rxByte;
        tgtOtp     <= strb.selOtp;
      end
      if (strb.loadLo) begin
        addrLoByte <= rxByte;
        fillPtr    <= '0;
        validMask  <= '0;
      end
      if (strb.pushData) begin
        validMask[slotIdx] <= 1'b1;
        fillPtr            <= fillPtr + 1'b1;
      end
      if (strb.commit && (|validMask)) begin
        busyCnt  <= TW'(TWR_CYCLES);
        flushing <= 1'b1;
        flushIdx <= '0;
      end else begin
        if (busy) busyCnt <= busyCnt - 1'b1;
        if (flushing) begin
          flushIdx <= flushIdx + 1'b1;
          if (flushIdx == PW'(PAGE_BYTES - 1)) begin
            flushing  <= 1'b0;
            validMask <= '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.pushData) pageBuf[slotIdx] <= rxByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memWe   <= 1'b0;
      memOtp  <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe   <= flushing && validMask[flushIdx];
      memOtp  <= tgtOtp;
      memAddr <= flushAddr;
      memData <= pageBuf[flushIdx];
    end
  end

endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave
  import eew_pkg::*;
#(
  parameter int         MEM_BYTES   = 256,
  parameter int         PAGE_BYTES  = 16,
  parameter int         TWR_CYCLES  = 600,
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] MAIN_SEL    = 3'b000,
  parameter logic [2:0] OTP_SEL     = 3'b001,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic          wcPin,
  input  logic          wcPol,
  output logic          sdaPullDown,
  output logic          memWe,
  output logic          memOtp,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memData
);

  ctlStrobe_t strb;
  logic [7:0] rxByte;
  logic       busy;

  eew_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .MAIN_SEL   (MAIN_SEL),
    .OTP_SEL    (OTP_SEL)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .wcPin      (wcPin),
    .wcPol      (wcPol),
    .busy       (busy),
    .strb       (strb),
    .rxByte     (rxByte),
    .sdaPullDown(sdaPullDown)
  );

  eew_data #(
    .MEM_BYTES (MEM_BYTES),
    .PAGE_BYTES(PAGE_BYTES),
    .TWR_CYCLES(TWR_CYCLES)
  ) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .rxByte (rxByte),
    .busy   (busy),
    .memWe  (memWe),
    .memOtp (memOtp),
    .memAddr(memAddr),
    .memData(memData)
  );

endmodule

// File: rtl/eew_checker.sv
module eew_checker (
  input logic clk,
  input logic rst_n,
  input logic sdaPullDown,
  input logic busy,
  input logic wcPin,
  input logic wcPol,
  input logic memWe,
  input logic clearBuf,
  input logic loadHi,
  input logic loadLo,
  input logic pushData,
  input logic commit
);

  // R6: off the bus during the internal write window
  p_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sdaPullDown);

  // R8: a data byte is taken only with write control at its enabling level
  p_push_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pushData |-> (wcPin == wcPol));

  // R3: the write window opens only right after a stop that ends a data phase
  p_busy_from_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));

  // R3: storage writes happen only inside the write window
  p_write_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> busy);

  // R2: at most one control strobe per clock
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clearBuf, loadHi, loadLo, pushData, commit}));

endmodule

bind eeprom_wr_slave eew_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sdaPullDown(sdaPullDown),
  .busy       (busy),
  .wcPin      (wcPin),
  .wcPol      (wcPol),
  .memWe      (memWe),
  .clearBuf   (strb.clearBuf),
  .loadHi     (strb.loadHi),
  .loadLo     (strb.loadLo),
  .pushData   (strb.pushData),
  .commit     (strb.commit)
);

// File: tb/eeprom_wr_slave_tb.sv
`timescale 1ns/1ps
module eeprom_wr_slave_tb;

  localparam int TWR = 600;
  localparam int Q   = 10;
  localparam logic [7:0] SEL_MAIN = 8'hA0;
  localparam logic [7:0] SEL_OTP  = 8'hA2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mScl = 1'b1;
  logic mSdaLow = 1'b0;
  logic wcPin = 1'b0;
  logic wcPol = 1'b0;
  logic sdaPullDown, memWe, memOtp;
  logic [7:0] memAddr, memData;
  logic sdaLine;

  assign sdaLine = ~(mSdaLow | sdaPullDown);

  always #2.5 clk = ~clk;

  eeprom_wr_slave #(.TWR_CYCLES(TWR)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclIn      (mScl),
    .sdaIn      (sdaLine),
    .wcPin      (wcPin),
    .wcPol      (wcPol),
    .sdaPullDown(sdaPullDown),
    .memWe      (memWe),
    .memOtp     (memOtp),
    .memAddr    (memAddr),
    .memData    (memData)
  );

  int total = 0;
  int bad = 0;
  int wrCount = 0;
  bit finished = 1'b0;
  logic [7:0] gotMain [256];
  logic [7:0] gotOtp  [16];
  logic [7:0] expMain [256];
  logic [7:0] expOtp  [16];

  initial begin
    for (int i = 0; i < 256; i++) begin gotMain[i] = 8'h00; expMain[i] = 8'h00; end
    for (int i = 0; i < 16; i++)  begin gotOtp[i]  = 8'h00; expOtp[i]  = 8'h00; end
  end

  always @(negedge clk) begin
    if (rst_n && memWe) begin
      wrCount++;
      if (memOtp) gotOtp[memAddr[3:0]] = memData;
      else        gotMain[memAddr]     = memData;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    mSdaLow = 1'b0; waitClk(Q);
    mScl = 1'b1;    waitClk(Q);
    mSdaLow = 1'b1; waitClk(Q);
    mScl = 1'b0;    waitClk(Q);
  endtask

  task automatic i2cStop();
    mSdaLow = 1'b1; waitClk(Q);
    mScl = 1'b1;    waitClk(Q);
    mSdaLow = 1'b0; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mSdaLow = ~b[i]; waitClk(Q);
      mScl = 1'b1;     waitClk(Q);
      if (i == 3) check(sdaPullDown == 1'b0, "R12 pull-down during data bit", sdaPullDown, 0);
      waitClk(Q);
      mScl = 1'b0;     waitClk(Q);
    end
    mSdaLow = 1'b0; waitClk(Q);
    mScl = 1'b1;    waitClk(Q);
    acked = sdaPullDown;
    waitClk(Q);
    mScl = 1'b0;    waitClk(Q);
  endtask

  task automatic sendExpect(input logic [7:0] b, input logic expAck, input string tag);
    logic a;
    sendByte(b, a);
    check(a == expAck, tag, a, expAck);
  endtask

  task automatic probeSelect(input logic expAck, input string tag);
    i2cStart();
    sendExpect(SEL_MAIN, expAck, tag);
    i2cStop();
  endtask

  task automatic waitWrite();
    waitClk(TWR + 40);
  endtask

  task automatic compareModel(input string tag);
    int miss = 0;
    for (int i = 0; i < 256; i++) if (gotMain[i] !== expMain[i]) miss++;
    for (int i = 0; i < 16; i++)  if (gotOtp[i]  !== expOtp[i])  miss++;
    check(miss == 0, tag, miss, 0);
  endtask

  task automatic tReset();
    check(sdaPullDown == 1'b0, "R11 pull-down after reset", sdaPullDown, 0);
    check(memWe == 1'b0, "R11 memWe after reset", memWe, 0);
    probeSelect(1'b1, "R11 select acked after reset");
  endtask

  task automatic tByteWrite();
    int w0 = wrCount;
    i2cStart();
    sendExpect(SEL_MAIN, 1'b1, "R1 main select ack");
    sendExpect(8'h00, 1'b1, "R2 high address ack");
    sendExpect(8'h05, 1'b1, "R2 low address ack");
    sendExpect(8'h5A, 1'b1, "R3 data byte ack");
    i2cStop();
    expMain[8'h05] = 8'h5A;
    probeSelect(1'b0, "R6 select refused in write window");
    waitWrite();
    check(wrCount - w0 == 1, "R3 one storage write", wrCount - w0, 1);
    compareModel("R3 byte write content");
  endtask

  task automatic tPageWrap();
    int w0 = wrCount;
    i2cStart();
    sendExpect(SEL_MAIN, 1'b1, "R1 main select ack");
    sendExpect(8'h00, 1'b1, "R2 high address ack");
    sendExpect(8'h13, 1'b1, "R2 low address ack");
    for (int k = 0; k < 18; k++) begin
      sendExpect(8'(8'h20 + k), 1'b1, "R4 page data ack");
      expMain[8'h10 + ((3 + k) % 16)] = 8'(8'h20 + k);
    end
    i2cStop();
    waitWrite();
    check(wrCount - w0 == 16, "R4 one write per slot", wrCount - w0, 16);
    compareModel("R4 page wrap content");
  endtask

  task automatic tPoll();
    logic a;
    int nacks = 0;
    i2cStart();
    sendExpect(SEL_MAIN, 1'b1, "R1 main select ack");
    sendExpect(8'h00, 1'b1, "R2 high address ack");
    sendExpect(8'h60, 1'b1, "R2 low address ack");
    sendExpect(8'hE1, 1'b1, "R4 page data ack");
    sendExpect(8'hE2, 1'b1, "R4 page data ack");
    i2cStop();
    expMain[8'h60] = 8'hE1;
    expMain[8'h61] = 8'hE2;
    for (int t = 0; t < 20; t++) begin
      i2cStart();
      sendByte(SEL_MAIN, a);
      if (a) break;
      nacks++;
      i2cStop();
    end
    check(nacks >= 1, "R6 polls refused during window", nacks, 1);
    check(a == 1'b1, "R7 poll finally acked", a, 1);
    sendExpect(8'h00, 1'b1, "R7 high address after poll");
    sendExpect(8'h40, 1'b1, "R7 low address after poll");
    sendExpect(8'h77, 1'b1, "R7 data after poll");
    i2cStop();
    expMain[8'h40] = 8'h77;
    waitWrite();
    compareModel("R7 content after polled write");
  endtask

  task automatic tOtpBad();
    int w0 = wrCount;
    i2cStart();
    sendExpect(SEL_OTP, 1'b1, "R1 one-time select ack");
    sendExpect(8'h00, 1'b1, "R2 high address ack");
    sendExpect(8'h04, 1'b1, "R5 bad low address still acked");
    sendExpect(8'h4D, 1'b0, "R5 data refused");
    sendExpect(8'hCA, 1'b0, "R5 data refused");
    sendExpect(8'h53, 1'b0, "R5 data refused");
    i2cStop();
    probeSelect(1'b1, "R5 no write window after refused data");
    waitClk(40);
    check(wrCount == w0, "R5 no storage write", wrCount - w0, 0);
  endtask

  task automatic tOtpGood();
    i2cStart();
    sendExpect(SEL_OTP, 1'b1, "R1 one-time select ack");
    sendExpect(8'h00, 1'b1, "R2 high address ack");
    sendExpect(8'h00, 1'b1, "R5 valid low address ack");
    sendExpect(8'h11, 1'b1, "R5 one-time data ack");
    sendExpect(8'h22, 1'b1, "R5 one-time data ack");
    i2cStop();
    expOtp[0] = 8'h11;
    expOtp[1] = 8'h22;
    waitWrite();
    compareModel("R5 one-time page content");
  endtask

  task automatic tBadSelect();
    int w0 = wrCount;
    i2cStart();
    sendExpect(8'hA1, 1'b0, "R1 read select refused");
    sendExpect(8'h00, 1'b0, "R1 ignored after refused select");
    sendExpect(8'h00, 1'b0, "R1 ignored after refused select");
    sendExpect(8'h99, 1'b0, "R1 ignored after refused select");
    i2cStop();
    i2cStart();
    sendExpect(8'hB0, 1'b0, "R1 wrong family refused");
    i2cStop();
    i2cStart();
    sendExpect(8'hA4, 1'b0, "R1 wrong bank refused");
    i2cStop();
    probeSelect(1'b1, "R1 no window after refused selects");
    check(wrCount == w0, "R1 no storage write", wrCount - w0, 0);
  endtask

  task automatic tWriteControl();
    int w0 = wrCount;
    wcPin = 1'b1; wcPol = 1'b0;
    i2cStart();
    sendExpect(SEL_MAIN, 1'b1, "R8 select acked while inhibited");
    sendExpect(8'h00, 1'b1, "R8 address acked while inhibited");
    sendExpect(8'h30, 1'b1, "R8 address acked while inhibited");
    sendExpect(8'h3C, 1'b0, "R8 data refused while inhibited");
    i2cStop();
    probeSelect(1'b1, "R8 no window while inhibited");
    check(wrCount == w0, "R8 no storage write", wrCount - w0, 0);
    wcPin = 1'b1; wcPol = 1'b1;
    i2cStart();
    sendExpect(SEL_MAIN, 1'b1, "R1 main select ack");
    sendExpect(8'h00, 1'b1, "R2 high address ack");
    sendExpect(8'h30, 1'b1, "R2 low address ack");
    sendExpect(8'hC3, 1'b1, "R8 data taken with both levels high");
    i2cStop();
    expMain[8'h30] = 8'hC3;
    waitWrite();
    compareModel("R8 content with both levels high");
    wcPin = 1'b0; wcPol = 1'b0;
  endtask

  task automatic tNoData();
    int w0 = wrCount;
    i2cStart();
    sendExpect(SEL_MAIN, 1'b1, "R1 main select ack");
    sendExpect(8'h00, 1'b1, "R2 high address ack");
    sendExpect(8'h10, 1'b1, "R2 low address ack");
    i2cStop();
    probeSelect(1'b1, "R9 no window without data");
    check(wrCount == w0, "R9 no storage write", wrCount - w0, 0);
  endtask

  task automatic tRestart();
    int w0 = wrCount;
    i2cStart();
    sendExpect(SEL_MAIN, 1'b1, "R1 main select ack");
    sendExpect(8'h00, 1'b1, "R2 high address ack");
    sendExpect(8'h20, 1'b1, "R2 low address ack");
    sendExpect(8'h99, 1'b1, "R10 data before restart acked");
    i2cStart();
    i2cStop();
    probeSelect(1'b1, "R10 no window after restart");
    waitClk(40);
    check(wrCount == w0, "R10 buffered data discarded", wrCount - w0, 0);
  endtask

  initial begin
    waitClk(8);
    rst_n = 1'b1;
    waitClk(8);
    tReset();
    tByteWrite();
    tPageWrap();
    tPoll();
    tOtpBad();
    tOtpGood();
    tBadSelect();
    tWriteControl();
    tNoData();
    tRestart();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule